// File: doc/BRIEF.md
# RV32I Next-PC and Branch Unit

This combinational unit resolves where a single RV32I instruction sends the program counter. It also produces the value that a jump or a PC-relative add writes back to the destination register. It takes five inputs: the current PC, the two source operand values, an immediate already sign-extended to 32 bits, and a 4-bit operation code. From these it computes four outputs: the next PC, a redirect flag, a result value for the destination register, and a flag that marks a transfer to a target that is not 4-byte aligned.

A single comparator serves all six conditional branches. It works out equality, unsigned less-than and signed less-than from one subtraction and then picks the one the operation asks for. The indirect-jump target has its lowest bit cleared. The return address PC + 4 comes from the same sequential adder that supplies the fall-through PC. Every addition wraps modulo 2^32. Fetching instructions, extracting the immediate and writing the register file are handled elsewhere.

Top module: `nxpc_unit`

## Requirements
- R1: Operation codes are: 0 sequential, 1 BEQ, 2 BNE, 3 BLT, 4 BGE, 5 BLTU, 6 BGEU, 7 JAL, 8 JALR, 9 AUIPC. Code 0 and the unused codes 10 to 15 give next_pc = pc + 4, redirect 0, rd value 0 and misaligned 0.
- R2: BEQ takes the branch when rs1 equals rs2. BNE takes it when they differ.
- R3: BLT takes the branch when rs1 < rs2 as two's-complement numbers. BGE takes it when rs1 >= rs2 as two's-complement numbers.
- R4: BLTU takes the branch when rs1 < rs2 as unsigned numbers. BGEU takes it when rs1 >= rs2 as unsigned numbers.
- R5: A taken branch gives next_pc = pc + imm and redirect 1. A branch not taken gives next_pc = pc + 4 and redirect 0. Both sums wrap modulo 2^32.
- R6: JAL always redirects, with next_pc = pc + imm (wrapping).
- R7: JALR always redirects, with next_pc = (rs1 + imm) with bit 0 forced to 0.
- R8: JAL and JALR output rd value pc + 4 (wrapping). Every branch outputs rd value 0.
- R9: AUIPC outputs rd value pc + imm, next_pc = pc + 4 and redirect 0.
- R10: The misaligned output is 1 exactly when redirect is 1 and either of next_pc bits 1 or 0 is set.
- R11: rs2 has no effect on any output for JAL, JALR, AUIPC or sequential operations. rs1 has no effect for JAL and AUIPC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Byte address of the current instruction |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source operand |
| imm_i | input | 32 | Sign-extended immediate |
| op_i | input | 4 | Operation code (see R1) |
| next_pc_o | output | 32 | Address of the next instruction |
| redirect_o | output | 1 | Taken branch or jump |
| rd_val_o | output | 32 | Value for the destination register |
| misalign_o | output | 1 | Redirect target not 4-byte aligned |

## Verification
The operand pairs for the compares are chosen so that the signed and unsigned orderings disagree. 0x80000000 against 0x7FFFFFFF, and 1 against 0xFFFFFFFF, separate a signed compare from an unsigned one. Equal operands, both positive and negative, separate strict from non-strict comparison. Targets that wrap past the top of the address space, backward branches with negative immediates, and JALR sums that are odd or have bit 1 set test the adder width, the clearing of bit 0, and the alignment flag. Changing an operand that should be ignored shows whether the operand selection is wrong.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    NX_SEQ   = 4'd0,
    NX_BEQ   = 4'd1,
    NX_BNE   = 4'd2,
    NX_BLT   = 4'd3,
    NX_BGE   = 4'd4,
    NX_BLTU  = 4'd5,
    NX_BGEU  = 4'd6,
    NX_JAL   = 4'd7,
    NX_JALR  = 4'd8,
    NX_AUIPC = 4'd9
  } nx_op_e;

  // which comparator result a branch looks at
  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_LTS = 2'd1,
    CMP_LTU = 2'd2
  } cmp_kind_e;

  typedef struct packed {
    logic      is_branch;
    cmp_kind_e kind;
    logic      invert;
    logic      is_jal;
    logic      is_jalr;
    logic      is_auipc;
  } nx_ctl_t;

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
  import nxpc_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output nx_ctl_t         ctl_o
);

  always_comb begin
    ctl_o = '{is_branch: 1'b0, kind: CMP_EQ, invert: 1'b0,
              is_jal: 1'b0, is_jalr: 1'b0, is_auipc: 1'b0};
    case (op_i)
      NX_BEQ:   begin ctl_o.is_branch = 1'b1; ctl_o.kind = CMP_EQ;  end
      NX_BNE:   begin ctl_o.is_branch = 1'b1; ctl_o.kind = CMP_EQ;  ctl_o.invert = 1'b1; end
      NX_BLT:   begin ctl_o.is_branch = 1'b1; ctl_o.kind = CMP_LTS; end
      NX_BGE:   begin ctl_o.is_branch = 1'b1; ctl_o.kind = CMP_LTS; ctl_o.invert = 1'b1; end
      NX_BLTU:  begin ctl_o.is_branch = 1'b1; ctl_o.kind = CMP_LTU; end
      NX_BGEU:  begin ctl_o.is_branch = 1'b1; ctl_o.kind = CMP_LTU; ctl_o.invert = 1'b1; end
      NX_JAL:   ctl_o.is_jal   = 1'b1;
      NX_JALR:  ctl_o.is_jalr  = 1'b1;
      NX_AUIPC: ctl_o.is_auipc = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/nxpc_cmp.sv
module nxpc_cmp
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  cmp_kind_e       kind_i,
  input  logic            invert_i,
  output logic            hit_o
);

  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN:0] diff;
  logic          eq, lt_u, lt_s, raw;

  // one subtractor: borrow out gives unsigned less-than
  assign diff = {1'b0, a_i} - {1'b0, b_i};
  assign eq   = (diff[XLEN-1:0] == '0);
  assign lt_u = diff[XLEN];
  // sign bits differ: the negative one is smaller; else unsigned order holds
  assign lt_s = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : lt_u;

  always_comb begin
    case (kind_i)
      CMP_LTS: raw = lt_s;
      CMP_LTU: raw = lt_u;
      default: raw = eq;
    endcase
  end

  assign hit_o = raw ^ invert_i;

endmodule

// File: rtl/nxpc_tgt.sv
module nxpc_tgt #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] rel_o,
  output logic [XLEN-1:0] ind_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] ind_sum;

  assign seq_o   = pc_i + STEP;
  assign rel_o   = pc_i + imm_i;
  assign ind_sum = rs1_i + imm_i;
  assign ind_o   = {ind_sum[XLEN-1:1], 1'b0};

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [OP_W-1:0] op_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] rd_val_o,
  output logic            misalign_o
);

  localparam int unsigned ALIGN_BITS = $clog2(INSN_BYTES);

  nx_ctl_t         ctl;
  logic            cond_hit;
  logic            br_taken;
  logic [XLEN-1:0] seq_pc, rel_pc, ind_pc;

  nxpc_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  nxpc_cmp #(.XLEN(XLEN)) u_cmp (
    .a_i      (rs1_i),
    .b_i      (rs2_i),
    .kind_i   (ctl.kind),
    .invert_i (ctl.invert),
    .hit_o    (cond_hit)
  );

  nxpc_tgt #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc_i  (pc_i),
    .rs1_i (rs1_i),
    .imm_i (imm_i),
    .seq_o (seq_pc),
    .rel_o (rel_pc),
    .ind_o (ind_pc)
  );

  assign br_taken   = ctl.is_branch & cond_hit;
  assign redirect_o = br_taken | ctl.is_jal | ctl.is_jalr;

  always_comb begin
    if (ctl.is_jalr)                 next_pc_o = ind_pc;
    else if (ctl.is_jal | br_taken)  next_pc_o = rel_pc;
    else                             next_pc_o = seq_pc;
  end

  always_comb begin
    if (ctl.is_jal | ctl.is_jalr) rd_val_o = seq_pc;
    else if (ctl.is_auipc)        rd_val_o = rel_pc;
    else                          rd_val_o = '0;
  end

  assign misalign_o = redirect_o & (|next_pc_o[ALIGN_BITS-1:0]);

endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [XLEN-1:0] imm_i,
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] rd_val_o,
  input logic            misalign_o
);

  logic [XLEN-1:0] fall_thru;
  logic            is_xfer, is_jump;

  assign fall_thru = pc_i + XLEN'(INSN_BYTES);
  assign is_jump   = (op_i == NX_JAL) || (op_i == NX_JALR);
  assign is_xfer   = is_jump || ((op_i >= NX_BEQ) && (op_i <= NX_BGEU));

  always_comb begin
    // R1 / R9: only branches and jumps may redirect
    assert_only_xfer_redirects_R1: assert (!(redirect_o && !is_xfer))
      else $error("redirect on non-transfer op");
    // R6 / R7: jumps are unconditional
    assert_jump_redirects_R6: assert (!(is_jump && !redirect_o))
      else $error("jump without redirect");
    // R5: no redirect means fall-through
    assert_fallthru_R5: assert (redirect_o || (next_pc_o == fall_thru))
      else $error("no redirect but next_pc not sequential");
    // R7: indirect target is even
    assert_jalr_even_R7: assert (!(op_i == NX_JALR && next_pc_o[0]))
      else $error("odd indirect target");
    // R8: jumps link the sequential address
    assert_link_value_R8: assert (!(is_jump && rd_val_o != fall_thru))
      else $error("bad link value");
    // R10: misaligned only on a redirect
    assert_misalign_gated_R10: assert (!(misalign_o && !redirect_o))
      else $error("misaligned without redirect");
    // R2: equal operands always take BEQ
    assert_beq_equal_R2: assert (!(op_i == NX_BEQ && rs1_i == rs2_i && !redirect_o))
      else $error("BEQ equal not taken");
  end

endmodule

bind nxpc_unit nxpc_unit_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) i_chk (
  .pc_i       (pc_i),
  .rs1_i      (rs1_i),
  .rs2_i      (rs2_i),
  .imm_i      (imm_i),
  .op_i       (op_i),
  .next_pc_o  (next_pc_o),
  .redirect_o (redirect_o),
  .rd_val_o   (rd_val_o),
  .misalign_o (misalign_o)
);

// File: tb/test_nxpc_unit.sv
module test_nxpc_unit;

  localparam int NV = 24;
  // entry: {op[4], pc[32], rs1[32], rs2[32], imm[32], expected_redirect[1]}
  localparam logic [132:0] VEC [NV] = '{
    {4'd1, 32'h00000100, 32'h00000005, 32'h00000005, 32'h00000010, 1'b1}, // R2 BEQ eq
    {4'd1, 32'h00000100, 32'h00000005, 32'h00000006, 32'h00000010, 1'b0}, // R2 BEQ ne
    {4'd2, 32'h00000100, 32'h00000005, 32'h00000006, 32'h00000010, 1'b1}, // R2 BNE ne
    {4'd2, 32'h00000100, 32'h80000000, 32'h80000000, 32'h00000010, 1'b0}, // R2 BNE eq
    {4'd3, 32'h00000100, 32'h80000000, 32'h7FFFFFFF, 32'h00000020, 1'b1}, // R3 BLT
    {4'd5, 32'h00000100, 32'h80000000, 32'h7FFFFFFF, 32'h00000020, 1'b0}, // R4 BLTU
    {4'd4, 32'h00000100, 32'h80000000, 32'h7FFFFFFF, 32'h00000020, 1'b0}, // R3 BGE
    {4'd6, 32'h00000100, 32'h80000000, 32'h7FFFFFFF, 32'h00000020, 1'b1}, // R4 BGEU
    {4'd4, 32'h00000100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000040, 1'b1}, // R3 BGE eq
    {4'd3, 32'h00000100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000040, 1'b0}, // R3 BLT eq
    {4'd5, 32'h00000100, 32'h00000001, 32'hFFFFFFFF, 32'h00000040, 1'b1}, // R4 BLTU
    {4'd3, 32'h00000100, 32'hFFFFFFFF, 32'h00000001, 32'h00000040, 1'b1}, // R3 BLT neg
    {4'd6, 32'h00000100, 32'h00000000, 32'h00000000, 32'h00000008, 1'b1}, // R4 BGEU eq
    {4'd5, 32'h00000100, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00000008, 1'b0}, // R4 BLTU eq
    {4'd3, 32'h00000200, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFF0, 1'b1}, // R5 backward
    {4'd7, 32'h00001000, 32'h12345678, 32'h9ABCDEF0, 32'h00000800, 1'b1}, // R6 JAL
    {4'd8, 32'h00001000, 32'h00002001, 32'h00000000, 32'h00000002, 1'b1}, // R7 JALR misal
    {4'd8, 32'h00001000, 32'h00003000, 32'h00000000, 32'hFFFFFFFF, 1'b1}, // R7 JALR odd
    {4'd9, 32'h00000400, 32'h00000000, 32'h00000000, 32'h12345000, 1'b0}, // R9 AUIPC
    {4'd0, 32'hFFFFFFFC, 32'h00000001, 32'h00000002, 32'h00000100, 1'b0}, // R1 seq wrap
    {4'hF, 32'h00000050, 32'h00000001, 32'h00000001, 32'h00000100, 1'b0}, // R1 unused code
    {4'd7, 32'hFFFFFFF0, 32'h00000000, 32'h00000000, 32'h00000020, 1'b1}, // R6 JAL wrap
    {4'd1, 32'h00000100, 32'h00000003, 32'h00000003, 32'h00000006, 1'b1}, // R10 misal br
    {4'd8, 32'h00000000, 32'h00004000, 32'h00000000, 32'h00000010, 1'b1}  // R7 JALR ok
  };

  logic        clk;
  logic [31:0] pc, rs1, rs2, imm;
  logic [3:0]  op;
  logic [31:0] next_pc, rd_val;
  logic        redirect, misalign;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  nxpc_unit i_nxpc_unit (
    .pc_i       (pc),
    .rs1_i      (rs1),
    .rs2_i      (rs2),
    .imm_i      (imm),
    .op_i       (op),
    .next_pc_o  (next_pc),
    .redirect_o (redirect),
    .rd_val_o   (rd_val),
    .misalign_o (misalign)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5, 4'd6: return "R4";
      4'd7:       return "R6";
      4'd8:       return "R7";
      4'd9:       return "R9";
      default:    return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected outputs written from the requirements
  task automatic expect_all(input string tag, input logic [3:0] o,
                            input logic [31:0] p, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] im);
    logic        tk;
    logic [31:0] npc, rdv;
    tk  = 1'b0;
    npc = p + 32'd4;
    rdv = 32'd0;
    case (o)
      4'd1: tk = (a == b);
      4'd2: tk = (a != b);
      4'd3: tk = ($signed(a) <  $signed(b));
      4'd4: tk = ($signed(a) >= $signed(b));
      4'd5: tk = (a <  b);
      4'd6: tk = (a >= b);
      4'd7: begin tk = 1'b1; rdv = p + 32'd4; end
      4'd8: begin tk = 1'b1; rdv = p + 32'd4; end
      4'd9: rdv = p + im;
      default: ;
    endcase
    if (o == 4'd8)      npc = (a + im) & 32'hFFFFFFFE;
    else if (tk)        npc = p + im;
    chk(tag, "redirect (R5)", {31'd0, redirect}, {31'd0, tk});
    chk(tag, "next_pc (R5)", next_pc, npc);
    chk(tag, "rd value (R8)", rd_val, rdv);
    chk("R10", "misaligned", {31'd0, misalign}, {31'd0, tk & (|npc[1:0])});
  endtask

  task automatic drive(input logic [3:0] o, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] im);
    @(negedge clk);
    op = o; pc = p; rs1 = a; rs2 = b; imm = im;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r_npc, r_rd;
    logic        r_red, r_mis;

    // R1: idle state with all inputs zero
    drive(4'd0, 32'd0, 32'd0, 32'd0, 32'd0);
    chk("R1", "idle next_pc", next_pc, 32'd4);
    chk("R1", "idle redirect", {31'd0, redirect}, 32'd0);
    chk("R1", "idle rd", rd_val, 32'd0);
    chk("R1", "idle misaligned", {31'd0, misalign}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [132:0] v;
      v = VEC[i];
      drive(v[132:129], v[128:97], v[96:65], v[64:33], v[32:1]);
      chk(req_of(v[132:129]), "table redirect", {31'd0, redirect}, {31'd0, v[0]});
      expect_all(req_of(v[132:129]), v[132:129], v[128:97], v[96:65], v[64:33], v[32:1]);
    end

    // R7: JALR target bit 0 cleared, bit 1 flagged
    drive(4'd8, 32'h100, 32'h00002001, 32'd0, 32'h2);
    chk("R7", "jalr target", next_pc, 32'h00002002);
    chk("R10", "jalr misaligned", {31'd0, misalign}, 32'd1);

    // R11: rs2 ignored by AUIPC, JAL, JALR, sequential; rs1 by JAL, AUIPC
    for (int k = 0; k < 4; k++) begin
      logic [3:0] o;
      o = (k == 0) ? 4'd9 : (k == 1) ? 4'd7 : (k == 2) ? 4'd8 : 4'd0;
      drive(o, 32'h00000800, 32'h00000010, 32'h00000000, 32'h00000040);
      r_npc = next_pc; r_rd = rd_val; r_red = redirect; r_mis = misalign;
      drive(o, 32'h00000800, 32'h00000010, 32'hDEADBEEF, 32'h00000040);
      chk("R11", "rs2 ignored next_pc", next_pc, r_npc);
      chk("R11", "rs2 ignored rd", rd_val, r_rd);
      chk("R11", "rs2 ignored flags", {30'd0, redirect, misalign}, {30'd0, r_red, r_mis});
      if (o == 4'd9 || o == 4'd7) begin
        drive(o, 32'h00000800, 32'hCAFEF00D, 32'hDEADBEEF, 32'h00000040);
        chk("R11", "rs1 ignored next_pc", next_pc, r_npc);
        chk("R11", "rs1 ignored rd", rd_val, r_rd);
      end
    end

    // R9: AUIPC with negative immediate, no redirect
    drive(4'd9, 32'h00001000, 32'd0, 32'd0, 32'hFFFFF000);
    chk("R9", "auipc rd", rd_val, 32'h00000000);
    chk("R9", "auipc next_pc", next_pc, 32'h00001004);

    finish_run();
  end

endmodule